// File: doc/BRIEF.md
# Triangle Spread-Spectrum Profile Generator

This block produces a signed 16-bit offset word that a fractional-N feedback divider adds to its nominal ratio. The divider ratio, and so the synthesized clock frequency, then sweeps along a symmetric triangle. The block runs from the reference clock, and every reference cycle is one profile step. Two profiles are available. The down profile keeps the offset at or below zero, so the frequency only drops below nominal (the lowest point sets the 0.5 % spread). The center profile swings the offset equally above and below zero, for ±0.25 % around nominal.

The enable is taken from an asynchronous pin unless a software-control input is set. In that case a register input supplies it. The profile type comes only from a register input, and 0 selects down spread. A reference-select input picks one of two step sizes, so the triangle period stays inside the 31.4 kHz to 33 kHz window for either a 25 MHz or a 14.31818 MHz reference. Both the enable and the profile type act only at a point where the offset is zero, so the frequency never jumps.

Top module: `spread_profile_gen`

## Requirements
- R1: After reset, offset_o is 0, active_o is 0 and rising_o is 1.
- R2: When sw_ctl_i is 0, the effective enable is pin_en_i after a two-flop synchronizer, and active_o rises on the third clock edge after the pin rises. When sw_ctl_i is 1, the effective enable is reg_en_i and active_o rises on the first edge. The unselected enable source has no effect.
- R3: Center profile (type_i=1). The offset sweeps from 0 upward to +PEAK, down to -PEAK and back. It reaches both peaks exactly.
- R4: Down profile (type_i=0). The offset sweeps from 0 down to -2*PEAK and back to 0, and it is never positive.
- R5: The offset changes by INC_FAST per cycle when ref_sel_i=0 and by INC_SLOW per cycle when ref_sel_i=1. The triangle period is 4*PEAK/inc cycles.
- R6: The direction reverses on the step after a peak is reached. rising_o is 1 while the offset is increasing and 0 while it is decreasing.
- R7: When the effective enable drops, the sweep continues to the next point where the offset is 0. On the following edge active_o falls. While active_o is 0, offset_o is held at 0.
- R8: A change of type_i takes effect only at a point where the offset is 0. Mid-sweep changes leave the current profile running.
- R9: The edge that raises active_o leaves the offset at 0. On the next step the offset goes positive in the center profile and negative in the down profile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate clock, one profile step per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_en_i | input | 1 | Asynchronous spread-enable pin |
| sw_ctl_i | input | 1 | 1: take the enable from reg_en_i instead of the pin |
| reg_en_i | input | 1 | Register spread enable |
| type_i | input | 1 | Profile type: 0 down, 1 center |
| ref_sel_i | input | 1 | Step size select: 0 INC_FAST, 1 INC_SLOW |
| offset_o | output | 16 | Signed offset in divider LSBs |
| rising_o | output | 1 | 1 while the offset is increasing |
| active_o | output | 1 | Sweep running |

## Verification
A table walks both profiles at both step sizes and samples the offset at the first step, at each peak, at the zero crossings and between them. This separates the two profile shapes, the two step sizes and the reversal points. Directed sequences then cover each enable source, including the source that is not selected. They also drop the enable in mid-sweep, to show that the stop waits for the zero crossing, and switch the type mid-sweep, to show that the old profile holds until the offset passes through zero.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int OFF_W = 16;
  typedef enum logic {
    SPREAD_DOWN   = 1'b0,
    SPREAD_CENTER = 1'b1
  } spread_mode_e;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ssc_en_sel.sv
module ssc_en_sel (
  input  logic pin_sync_i,
  input  logic sw_ctl_i,
  input  logic reg_en_i,
  output logic en_o
);
  assign en_o = sw_ctl_i ? reg_en_i : pin_sync_i;
endmodule

// File: rtl/ssc_tri_core.sv
module ssc_tri_core
  import ssc_pkg::*;
#(
  parameter int PEAK     = 784,
  parameter int INC_FAST = 4,
  parameter int INC_SLOW = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    type_i,
  input  logic                    ref_sel_i,
  output logic signed [OFF_W-1:0] offset_o,
  output logic                    rising_o,
  output logic                    active_o
);
  localparam int XW = OFF_W + 1;
  localparam logic signed [XW-1:0] PK_X  = XW'(PEAK);
  localparam logic signed [XW-1:0] PK2_X = XW'(2 * PEAK);
  localparam logic signed [XW-1:0] INF_X = XW'(INC_FAST);
  localparam logic signed [XW-1:0] INS_X = XW'(INC_SLOW);

  logic signed [OFF_W-1:0] off_q, off_n;
  logic                    dir_q, dir_n;
  logic                    run_q;
  spread_mode_e            mode_q, mode_eff;
  logic signed [XW-1:0]    off_x, hi_x, lo_x, inc_x, up_x, dn_x, up_c, dn_c;
  logic                    at_zero;

  assign at_zero  = (off_q == '0);
  // profile type only switches where the offset is zero
  assign mode_eff = at_zero ? spread_mode_e'(type_i) : mode_q;
  assign off_x    = XW'(off_q);
  assign hi_x     = (mode_eff == SPREAD_CENTER) ? PK_X : '0;
  assign lo_x     = (mode_eff == SPREAD_CENTER) ? -PK_X : -PK2_X;
  assign inc_x    = ref_sel_i ? INS_X : INF_X;
  assign up_x     = off_x + inc_x;
  assign dn_x     = off_x - inc_x;
  assign up_c     = (up_x > hi_x) ? hi_x : up_x;
  assign dn_c     = (dn_x < lo_x) ? lo_x : dn_x;

  always_comb begin
    dir_n = dir_q;
    off_n = off_q;
    if (dir_q) begin
      if (off_x >= hi_x) begin
        dir_n = 1'b0;
        off_n = dn_c[OFF_W-1:0];
      end else begin
        off_n = up_c[OFF_W-1:0];
      end
    end else begin
      if (off_x <= lo_x) begin
        dir_n = 1'b1;
        off_n = up_c[OFF_W-1:0];
      end else begin
        off_n = dn_c[OFF_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      off_q  <= '0;
      dir_q  <= 1'b1;
      mode_q <= SPREAD_DOWN;
    end else if (!run_q) begin
      off_q <= '0;
      dir_q <= 1'b1;
      if (en_i) begin
        run_q  <= 1'b1;
        mode_q <= spread_mode_e'(type_i);
      end
    end else if (at_zero && !en_i) begin
      run_q <= 1'b0;
      dir_q <= 1'b1;
    end else begin
      off_q  <= off_n;
      dir_q  <= dir_n;
      mode_q <= mode_eff;
    end
  end

  assign offset_o = off_q;
  assign rising_o = dir_q;
  assign active_o = run_q;
endmodule

// File: rtl/spread_profile_gen.sv
module spread_profile_gen
  import ssc_pkg::*;
#(
  parameter int PEAK        = 784,
  parameter int INC_FAST    = 4,
  parameter int INC_SLOW    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_en_i,
  input  logic              sw_ctl_i,
  input  logic              reg_en_i,
  input  logic              type_i,
  input  logic              ref_sel_i,
  output logic [OFF_W-1:0]  offset_o,
  output logic              rising_o,
  output logic              active_o
);
  logic pin_sync, en_eff;
  logic signed [OFF_W-1:0] off_s;

  ssc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_en_i),
    .q_o   (pin_sync)
  );

  ssc_en_sel u_en_sel (
    .pin_sync_i(pin_sync),
    .sw_ctl_i  (sw_ctl_i),
    .reg_en_i  (reg_en_i),
    .en_o      (en_eff)
  );

  ssc_tri_core #(
    .PEAK    (PEAK),
    .INC_FAST(INC_FAST),
    .INC_SLOW(INC_SLOW)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_eff),
    .type_i   (type_i),
    .ref_sel_i(ref_sel_i),
    .offset_o (off_s),
    .rising_o (rising_o),
    .active_o (active_o)
  );

  assign offset_o = off_s;
endmodule

// File: rtl/spread_profile_chk.sv
module spread_profile_chk #(
  parameter int PEAK     = 784,
  parameter int INC_FAST = 4,
  parameter int INC_SLOW = 7
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sw_ctl_i,
  input logic        reg_en_i,
  input logic [15:0] offset_o,
  input logic        active_o
);
  localparam int INC_MAX = (INC_FAST > INC_SLOW) ? INC_FAST : INC_SLOW;

  logic signed [16:0] off_x, off_p, diff;
  logic               past_ok;

  assign off_x = 17'(signed'(offset_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_p   <= '0;
      past_ok <= 1'b0;
    end else begin
      off_p   <= off_x;
      past_ok <= 1'b1;
    end
  end

  assign diff = off_x - off_p;

  // R3 R4
  offset_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_x <= 17'(PEAK)) && (off_x >= -17'(2 * PEAK)));

  // R5
  step_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((diff <= 17'(INC_MAX)) && (diff >= -17'(INC_MAX))));

  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (offset_o == '0));

  // R7
  stop_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $fell(active_o) |-> (off_p == '0));

  // R2
  reg_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_ctl_i && !reg_en_i && !active_o) |=> !active_o);
endmodule

bind spread_profile_gen spread_profile_chk #(
  .PEAK    (PEAK),
  .INC_FAST(INC_FAST),
  .INC_SLOW(INC_SLOW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sw_ctl_i(sw_ctl_i),
  .reg_en_i(reg_en_i),
  .offset_o(offset_o),
  .active_o(active_o)
);

// File: tb/spread_profile_gen_tb.sv
module spread_profile_gen_tb;
  localparam int P = 12;
  localparam int NV = 14;
  // type (1 center), ref_sel, steps after start, expected offset
  localparam int V_TYP [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0};
  localparam int V_SEL [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 1, 1};
  localparam int V_N   [NV] = '{1, 4, 8, 12, 14, 3, 6, 9, 1, 5, 8, 16, 3, 6};
  localparam int V_EXP [NV] = '{3, 12, 0, -12, -6, 12, 0, -12, -3, -15, -24, 0, -12, -24};

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_en = 0, sw_ctl = 0, reg_en = 0, typ = 0, ref_sel = 0;
  logic [15:0] offset;
  logic rising, active;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spread_profile_gen #(.PEAK(P), .INC_FAST(3), .INC_SLOW(4), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_en_i(pin_en), .sw_ctl_i(sw_ctl),
    .reg_en_i(reg_en), .type_i(typ), .ref_sel_i(ref_sel),
    .offset_o(offset), .rising_o(rising), .active_o(active)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pin_en = 0; sw_ctl = 0; reg_en = 0; typ = 0; ref_sel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // start via register path; returns 1 ns after the edge that raises active
  task automatic start_reg(input logic t, input logic s);
    @(negedge clk);
    sw_ctl = 1; typ = t; ref_sel = s; reg_en = 1;
    steps(1);
  endtask

  function automatic int soff();
    return int'(signed'(offset));
  endfunction

  initial begin
    do_reset();
    #1;
    chk("R1 offset", soff(), 0);
    chk("R1 active", int'(active), 0);
    chk("R1 rising", int'(rising), 1);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      start_reg(V_TYP[i][0], V_SEL[i][0]);
      steps(V_N[i]);
      chk(V_N[i] == 1 ? "R9 first step" :
          V_SEL[i] == 1 ? "R5 slow step" :
          V_TYP[i] == 1 ? "R3 center" : "R4 down", soff(), V_EXP[i]);
    end

    // R2 pin path through synchronizer
    do_reset();
    @(negedge clk); pin_en = 1;
    steps(2);
    chk("R2 pin latency", int'(active), 0);
    steps(1);
    chk("R2 pin start", int'(active), 1);

    // R2 register enable ignored while pin selected
    do_reset();
    @(negedge clk); reg_en = 1;
    steps(6);
    chk("R2 reg ignored", int'(active), 0);

    // R2 pin ignored while software control set
    do_reset();
    @(negedge clk); sw_ctl = 1; pin_en = 1;
    steps(6);
    chk("R2 pin ignored", int'(active), 0);

    // R6 direction
    do_reset();
    start_reg(1, 0);
    chk("R9 start offset", soff(), 0);
    steps(3);  chk("R6 rising up", int'(rising), 1);
    steps(2);  chk("R6 falling", int'(rising), 0);
    steps(8);  chk("R6 rising again", int'(rising), 1);

    // R7 disable waits for zero
    do_reset();
    start_reg(1, 0);
    steps(2);
    @(negedge clk); reg_en = 0;
    steps(5);  chk("R7 still running", soff(), 3);
    chk("R7 active", int'(active), 1);
    steps(1);  chk("R7 at zero", soff(), 0);
    steps(1);  chk("R7 stopped", int'(active), 0);
    steps(5);  chk("R7 held zero", soff(), 0);

    // R8 type change applied only at zero
    do_reset();
    start_reg(1, 0);
    steps(2);
    @(negedge clk); typ = 0;
    steps(2);  chk("R8 old profile", soff(), 12);
    steps(12); chk("R8 new profile", soff(), -24);
    steps(9);  chk("R8 never positive", soff(), -3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule